// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block gathers sixteen interrupt request lines into one interrupt signal for a processor. Two identical eight-input stages do the work. The secondary stage takes system lines 8 to 15. Its combined request takes the place of input 2 of the primary stage, and only the primary stage drives the processor. For that reason line 2 cannot be used by an external source. Each stage keeps three registers: one of pending requests, one of masks and one of the inputs currently in service.

The processor pulses `inta` while `int_out` is high. The controller then moves the winning request into service and, one cycle later, presents an 8-bit vector equal to a programmable base plus the line number. When the handler finishes, the processor pulses `eoi` with the line number, and that in-service state is retired. A small write-only port sets the masks, the per-line trigger type (edge or level), the vector base and the priority mode (fixed or rotating).

Top module: `pic_cascade`

## Requirements
- R1: After reset `int_out`, `vec_valid` and `vec_out` are 0. All lines are unmasked and edge-triggered, the vector base is 0 and fixed priority is in force.
- R2: An edge-triggered line is latched by a rising edge and raises `int_out` at the first clock edge that samples it high. The request stays pending after the line falls, until it is acknowledged.
- R3: An `inta` pulse while `int_out` is high gives `vec_valid` high for the following cycle, with `vec_out` = base + line (lines 0..15). An `inta` while `int_out` is low gives no vector. The base is written at address 4.
- R4: In fixed mode lower line numbers win within a stage, and lines 8..15 all rank at the position of primary input 2. So line 1 beats line 8, line 8 beats line 3, and line 10 beats line 7.
- R5: While a line is in service, requests of equal or lower priority keep `int_out` low, and a request of higher priority still raises it.
- R6: An `eoi` naming line 0..7 clears that line's in-service bit, and pending requests it was blocking are then forwarded. An `eoi` naming line 2 has no effect.
- R7: Acknowledging a line 8..15 puts both primary input 2 and the secondary input in service. This blocks the other secondary lines. An `eoi` naming that line clears both bits.
- R8: Mask registers are at address 0 (lines 0..7, bit n = line n) and address 1 (lines 8..15, bit n = line 8+n). A 1 keeps that line from raising `int_out`, and clearing the bit lets its pending request through.
- R9: Trigger registers are at address 2 (primary) and address 3 (secondary), with bit 1 = level. A level line is pending for as long as it is high. An acknowledge does not clear it, and it stops being pending once the line is low.
- R10: Bit 0 of address 5 selects rotating priority. In that mode, after an `eoi` the named input becomes the lowest priority of its stage. Returning to fixed mode restores line 0 as the highest.
- R11: `irq_in[2]` has no effect, because primary input 2 carries the secondary stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 16 | Request lines 0..15; bit 2 unused |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration register address |
| wr_data | input | 8 | Configuration write data |
| inta | input | 1 | Interrupt-acknowledge pulse |
| eoi | input | 1 | End-of-interrupt pulse |
| eoi_line | input | 4 | Line retired by `eoi` |
| int_out | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector valid, one cycle after an accepted acknowledge |
| vec_out | output | 8 | Vector number |

## Verification
A wrong request or in-service bit shows at `int_out` within one cycle, because the interrupt output is combinational from those registers. A bench can therefore probe blocking and release at the very next sample after a pulse, a write or a retirement. A lost in-service bit lets a lower request through early. A stuck bit keeps `int_out` low after the `eoi` that should have freed it. A wrong priority pointer or a wrong cascade selection shows in the vector returned one cycle after the acknowledge.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int unsigned PIC_AW = 3;

   typedef enum logic [PIC_AW-1:0] {
      CFG_MASK_PRI  = 3'd0,
      CFG_MASK_SEC  = 3'd1,
      CFG_TRIG_PRI  = 3'd2,
      CFG_TRIG_SEC  = 3'd3,
      CFG_VEC_BASE  = 3'd4,
      CFG_MODE      = 3'd5
   } cfg_addr_e;
endpackage

// File: rtl/pic_cfg_regs.sv
module pic_cfg_regs
   import pic_pkg::*;
#(
   parameter int unsigned N     = 8,
   parameter int unsigned VEC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PIC_AW-1:0] wr_addr,
   input  logic [VEC_W-1:0] wr_data,
   output logic [N-1:0]     mask_pri,
   output logic [N-1:0]     mask_sec,
   output logic [N-1:0]     trig_pri,
   output logic [N-1:0]     trig_sec,
   output logic [VEC_W-1:0] vec_base,
   output logic             rotate
);
   if (N > VEC_W) begin : g_bad_width
      $error("pic_cfg_regs: stage width exceeds write data width");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_pri <= '0;
         mask_sec <= '0;
         trig_pri <= '0;
         trig_sec <= '0;
         vec_base <= '0;
         rotate   <= 1'b0;
      end else if (wr_en) begin
         case (cfg_addr_e'(wr_addr))
            CFG_MASK_PRI: mask_pri <= wr_data[N-1:0];
            CFG_MASK_SEC: mask_sec <= wr_data[N-1:0];
            CFG_TRIG_PRI: trig_pri <= wr_data[N-1:0];
            CFG_TRIG_SEC: trig_sec <= wr_data[N-1:0];
            CFG_VEC_BASE: vec_base <= wr_data;
            CFG_MODE:     rotate   <= wr_data[0];
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0]         cand,
   input  logic [N-1:0]         isr,
   input  logic [$clog2(N)-1:0] base,
   output logic [$clog2(N)-1:0] win,
   output logic                 win_valid,
   output logic                 req_out
);
   localparam int unsigned IW = $clog2(N);

   logic [IW-1:0] win_rank;
   logic [IW-1:0] isr_rank;
   logic          isr_any;

   // Scan ranks from lowest to highest so the last hit is the best one.
   always_comb begin
      win       = '0;
      win_valid = 1'b0;
      win_rank  = '0;
      isr_rank  = '0;
      isr_any   = 1'b0;
      for (int r = N - 1; r >= 0; r--) begin
         automatic logic [IW-1:0] idx = base + IW'(r);
         if (cand[idx]) begin
            win       = idx;
            win_valid = 1'b1;
            win_rank  = IW'(r);
         end
         if (isr[idx]) begin
            isr_any  = 1'b1;
            isr_rank = IW'(r);
         end
      end
      req_out = win_valid && (!isr_any || (win_rank < isr_rank));
   end
endmodule

// File: rtl/pic_stage.sv
module pic_stage #(
   parameter int unsigned  N      = 8,
   parameter logic [N-1:0] DIRECT = '0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req_in,
   input  logic [N-1:0]         trig,
   input  logic [N-1:0]         mask,
   input  logic                 rotate,
   input  logic                 ack_en,
   input  logic                 eoi_en,
   input  logic [$clog2(N)-1:0] eoi_idx,
   output logic                 req_out,
   output logic [$clog2(N)-1:0] win,
   output logic                 win_valid,
   output logic [N-1:0]         isr_out
);
   localparam int unsigned IW = $clog2(N);

   if ((N & (N - 1)) != 0) begin : g_bad_n
      $error("pic_stage: N must be a power of two");
   end

   logic [N-1:0]  in_q, irr_q, isr_q;
   logic [N-1:0]  rise, irr_eff, cand, ack_oh, eoi_oh, irr_d;
   logic [IW-1:0] base_q;

   assign rise    = req_in & ~in_q;
   // Direct inputs (a chained stage) bypass the request register.
   assign irr_eff = (irr_q & ~DIRECT) | (req_in & DIRECT);
   assign cand    = irr_eff & ~mask;

   pic_resolver #(.N(N)) u_res (
      .cand      (cand),
      .isr       (isr_q),
      .base      (base_q),
      .win       (win),
      .win_valid (win_valid),
      .req_out   (req_out)
   );

   assign ack_oh = (ack_en && win_valid) ? (N'(1) << win) : '0;
   assign eoi_oh = eoi_en ? (N'(1) << eoi_idx) : '0;
   assign irr_d  = (trig & req_in) | (~trig & ((irr_q & ~ack_oh) | rise));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_q   <= '0;
         irr_q  <= '0;
         isr_q  <= '0;
         base_q <= '0;
      end else begin
         in_q  <= req_in;
         irr_q <= irr_d & ~DIRECT;
         isr_q <= (isr_q & ~eoi_oh) | ack_oh;
         if (!rotate)
            base_q <= '0;
         else if (eoi_en)
            base_q <= eoi_idx + 1'b1;
      end
   end

   assign isr_out = isr_q;

   // R3: an accepted acknowledge puts the winner in service
   a_r3_ack_sets_isr: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_en && win_valid && !(eoi_en && eoi_idx == win)) |=> isr_q[$past(win)]);

   // R6: end-of-interrupt retires the named bit
   a_r6_eoi_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_en && !(ack_en && win_valid && win == eoi_idx)) |=> !isr_q[$past(eoi_idx)]);

   // R8: a masked input never wins arbitration
   a_r8_masked_never_wins: assert property (@(posedge clk) disable iff (!rst_n)
      win_valid |-> !mask[win]);

   for (genvar i = 0; i < N; i++) begin : g_bit
      if (!DIRECT[i]) begin : g_latched
         // R2: an edge request is captured and held until acknowledged
         a_r2_edge_capture: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig[i] && rise[i]) |=> irr_q[i]);
         a_r2_edge_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!trig[i] && irr_q[i] && !ack_oh[i]) |=> irr_q[i]);
      end
   end
endmodule

// File: rtl/pic_cascade.sv
module pic_cascade
   import pic_pkg::*;
#(
   parameter int unsigned STAGE_IN = 8,
   parameter int unsigned CASC_IN  = 2,
   parameter int unsigned VEC_W    = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*STAGE_IN-1:0] irq_in,
   input  logic                  wr_en,
   input  logic [PIC_AW-1:0]     wr_addr,
   input  logic [VEC_W-1:0]      wr_data,
   input  logic                  inta,
   input  logic                  eoi,
   input  logic [$clog2(STAGE_IN):0] eoi_line,
   output logic                  int_out,
   output logic                  vec_valid,
   output logic [VEC_W-1:0]      vec_out
);
   localparam int unsigned IW = $clog2(STAGE_IN);
   localparam int unsigned LW = IW + 1;
   localparam logic [IW-1:0]       CASC_IDX = IW'(CASC_IN);
   localparam logic [STAGE_IN-1:0] CASC_OH  = STAGE_IN'(1) << CASC_IN;

   if (CASC_IN >= STAGE_IN) begin : g_bad_casc
      $error("pic_cascade: cascade input out of range");
   end
   if (VEC_W < LW) begin : g_bad_vec
      $error("pic_cascade: vector too narrow for line numbers");
   end

   logic [STAGE_IN-1:0] mask_pri, mask_sec, trig_pri, trig_sec;
   logic [VEC_W-1:0]    vec_base;
   logic                rotate;

   pic_cfg_regs #(.N(STAGE_IN), .VEC_W(VEC_W)) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .mask_pri (mask_pri),
      .mask_sec (mask_sec),
      .trig_pri (trig_pri),
      .trig_sec (trig_sec),
      .vec_base (vec_base),
      .rotate   (rotate)
   );

   logic                s_req, s_valid, p_valid, p_ack, s_ack;
   logic [IW-1:0]       s_win, p_win;
   logic [STAGE_IN-1:0] s_isr, p_isr, p_req_in;
   logic                line_hi;
   logic [IW-1:0]       line_lo;
   logic                p_eoi_en, s_eoi_en;
   logic [IW-1:0]       p_eoi_idx;

   assign line_hi   = eoi_line[LW-1];
   assign line_lo   = eoi_line[IW-1:0];
   assign p_eoi_en  = eoi && (line_hi || (line_lo != CASC_IDX));
   assign p_eoi_idx = line_hi ? CASC_IDX : line_lo;
   assign s_eoi_en  = eoi && line_hi;

   assign p_req_in = (irq_in[STAGE_IN-1:0] & ~CASC_OH) | (CASC_OH & {STAGE_IN{s_req}});
   assign p_ack    = inta && int_out;
   assign s_ack    = p_ack && (p_win == CASC_IDX);

   pic_stage #(.N(STAGE_IN), .DIRECT('0)) u_sec (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (irq_in[2*STAGE_IN-1:STAGE_IN]),
      .trig      (trig_sec),
      .mask      (mask_sec),
      .rotate    (rotate),
      .ack_en    (s_ack),
      .eoi_en    (s_eoi_en),
      .eoi_idx   (line_lo),
      .req_out   (s_req),
      .win       (s_win),
      .win_valid (s_valid),
      .isr_out   (s_isr)
   );

   pic_stage #(.N(STAGE_IN), .DIRECT(CASC_OH)) u_pri (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (p_req_in),
      .trig      (trig_pri),
      .mask      (mask_pri),
      .rotate    (rotate),
      .ack_en    (p_ack),
      .eoi_en    (p_eoi_en),
      .eoi_idx   (p_eoi_idx),
      .req_out   (int_out),
      .win       (p_win),
      .win_valid (p_valid),
      .isr_out   (p_isr)
   );

   logic [LW-1:0] ack_line;
   assign ack_line = s_ack ? {1'b1, s_win} : {1'b0, p_win};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         vec_valid <= p_ack;
         if (p_ack)
            vec_out <= vec_base + VEC_W'(ack_line);
      end
   end

   // R7: secondary in-service state always pairs with primary input 2
   a_r7_cascade_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (|s_isr) == p_isr[CASC_IN]);

   // R7: a secondary acknowledge only happens with a secondary winner
   a_r7_sec_ack_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
      s_ack |-> (s_valid && p_valid));
endmodule

// File: tb/tb_pic_cascade.sv
`timescale 1ns/1ps
module tb_pic_cascade;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_in = '0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        inta = 1'b0;
   logic        eoi = 1'b0;
   logic [3:0]  eoi_line = '0;
   logic        int_out, vec_valid;
   logic [7:0]  vec_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   localparam logic [7:0] BASE = 8'h20;

   always #2.5 clk = ~clk;

   pic_cascade dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .inta(inta), .eoi(eoi),
      .eoi_line(eoi_line), .int_out(int_out), .vec_valid(vec_valid),
      .vec_out(vec_out)
   );

   // pattern of lines pulsed together, and the line expected to win (R4)
   localparam logic [15:0] T_PAT [0:8] = '{16'h0001, 16'h0080, 16'h0100, 16'h8000,
      16'h0108, 16'h0102, 16'hA000, 16'h0480, 16'h00F0};
   localparam logic [3:0]  T_EXP [0:8] = '{4'd0, 4'd7, 4'd8, 4'd15, 4'd8, 4'd1,
      4'd13, 4'd10, 4'd4};

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic pulse(input logic [15:0] m);
      @(negedge clk); irq_in = irq_in | m;
      @(negedge clk); irq_in = irq_in & ~m;
   endtask

   task automatic ack(output logic [7:0] v, output logic ok);
      @(negedge clk); inta = 1'b1;
      @(negedge clk); inta = 1'b0; v = vec_out; ok = vec_valid;
   endtask

   task automatic retire(input logic [3:0] line);
      @(negedge clk); eoi = 1'b1; eoi_line = line;
      @(negedge clk); eoi = 1'b0;
   endtask

   task automatic ack_expect(input string tag, input logic [3:0] line);
      logic [7:0] v; logic ok;
      ack(v, ok);
      check({tag, " vec_valid"}, 32'(ok), 32'd1);
      check({tag, " vector"}, 32'(v), 32'(BASE + 8'(line)));
   endtask

   task automatic drain();
      logic [7:0] v; logic ok;
      for (int k = 0; k < 20; k++) begin
         if (!int_out) break;
         ack(v, ok);
         retire(4'(v - BASE));
      end
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0] v; logic ok;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 int_out", 32'(int_out), 0);
      check("R1 vec_valid", 32'(vec_valid), 0);
      check("R1 vec_out", 32'(vec_out), 0);

      // R3: acknowledge with nothing pending gives no vector
      ack(v, ok);
      check("R3 idle inta", 32'(ok), 0);

      wr(3'd4, BASE);

      // R4: table of simultaneous requests in fixed mode
      for (int t = 0; t < 9; t++) begin
         pulse(T_PAT[t]);
         check("R4 int raised", 32'(int_out), 1);
         ack_expect("R4", T_EXP[t]);
         retire(T_EXP[t]);
         drain();
      end

      // R2: edge capture timing and hold after the line drops
      @(negedge clk); irq_in[5] = 1'b1;
      check("R2 no int before edge", 32'(int_out), 0);
      @(negedge clk);
      check("R2 int after edge", 32'(int_out), 1);
      irq_in[5] = 1'b0;
      repeat (3) @(negedge clk);
      check("R2 held after drop", 32'(int_out), 1);
      ack_expect("R2", 4'd5);

      // R5: line 5 in service; lower 6 blocked, higher 3 forwarded
      pulse(16'h0040);
      check("R5 lower blocked", 32'(int_out), 0);
      pulse(16'h0008);
      check("R5 higher passes", 32'(int_out), 1);
      ack_expect("R5", 4'd3);
      retire(4'd3);
      check("R5 still blocked by 5", 32'(int_out), 0);
      retire(4'd2);
      check("R6 eoi line 2 ignored", 32'(int_out), 0);
      retire(4'd5);
      check("R6 release after eoi", 32'(int_out), 1);
      ack_expect("R6", 4'd6);
      retire(4'd6);
      check("R6 idle", 32'(int_out), 0);

      // R7: secondary in service blocks its siblings but not line 1
      pulse(16'h1200);
      ack_expect("R7 first", 4'd9);
      check("R7 sibling blocked", 32'(int_out), 0);
      pulse(16'h0002);
      check("R7 line 1 passes", 32'(int_out), 1);
      ack_expect("R7 nested", 4'd1);
      retire(4'd1);
      check("R7 cascade still busy", 32'(int_out), 0);
      retire(4'd9);
      check("R7 released", 32'(int_out), 1);
      ack_expect("R7 second", 4'd12);
      retire(4'd12);

      // R8: masks
      wr(3'd0, 8'h08);
      pulse(16'h0008);
      check("R8 masked primary", 32'(int_out), 0);
      wr(3'd0, 8'h00);
      check("R8 unmask primary", 32'(int_out), 1);
      ack_expect("R8 primary", 4'd3);
      retire(4'd3);
      wr(3'd1, 8'h04);
      pulse(16'h0400);
      check("R8 masked secondary", 32'(int_out), 0);
      wr(3'd1, 8'h00);
      check("R8 unmask secondary", 32'(int_out), 1);
      ack_expect("R8 secondary", 4'd10);
      retire(4'd10);

      // R9: level-triggered line 0
      wr(3'd2, 8'h01);
      @(negedge clk); irq_in[0] = 1'b1;
      @(negedge clk);
      check("R9 level pending", 32'(int_out), 1);
      ack_expect("R9 first", 4'd0);
      retire(4'd0);
      check("R9 not cleared by ack", 32'(int_out), 1);
      ack_expect("R9 again", 4'd0);
      retire(4'd0);
      irq_in[0] = 1'b0;
      @(negedge clk);
      check("R9 dropped", 32'(int_out), 0);
      wr(3'd2, 8'h00);

      // R10: rotating priority
      wr(3'd5, 8'h01);
      pulse(16'h0042);
      ack_expect("R10 first", 4'd1);
      retire(4'd1);
      pulse(16'h0001);
      ack_expect("R10 rotated", 4'd6);
      retire(4'd6);
      ack_expect("R10 last", 4'd0);
      retire(4'd0);
      wr(3'd5, 8'h00);
      pulse(16'h0081);
      ack_expect("R10 fixed again", 4'd0);
      retire(4'd0);
      drain();

      // R11: external line 2 has no effect
      @(negedge clk); irq_in[2] = 1'b1;
      repeat (2) @(negedge clk);
      check("R11 line 2 ignored", 32'(int_out), 0);
      irq_in[2] = 1'b0;
      @(negedge clk);
      check("R11 still idle", 32'(int_out), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule